// File: doc/BRIEF.md
# Backoff Spin Lock Requester

This block sits beside one processor and wins a shared lock word for it. A local client raises an acquire request. The engine then reads the lock word with ordinary reads for as long as the word reads busy. When a read returns clear, it sends an atomic test-and-set at once. If the old value that comes back is clear, the lock is taken and the grant output rises. If the old value is busy, another requester got there first. That counts as a collision, and the engine stays off the memory port for a backoff period before it starts polling again.

The backoff period always starts at its minimum when a new acquisition begins. It doubles after each further collision and stops growing at a configured maximum. The client keeps the grant until it pulses release. The engine then sends one write that clears the lock word. Memory is reached through a valid/ready request channel and a separate response-valid pulse. Only one request is in flight at a time.

Top module: `lock_requester`

## Requirements
- R1: Out of reset, no memory request is valid and grant is low. Both stay that way until the client requests the lock.
- R2: A read response of 1 (busy) is followed by another read request (op code 00). No test-and-set (op code 01) is sent unless the most recent read response returned 0 (clear).
- R3: A read response of 0 is followed by a test-and-set request in the very next cycle, with no delay.
- R4: A test-and-set response of 0 (old value clear) raises grant in the next cycle. The lock word then holds 1.
- R5: A test-and-set response of 1 is a collision. Request valid stays low for exactly D cycles after the response cycle, and the next request is a read.
- R6: The delay D for the first collision of every acquisition equals MIN_DELAY. This holds even right after an earlier successful acquisition.
- R7: Each further collision in the same acquisition doubles D, and D never exceeds MAX_DELAY.
- R8: Grant stays high until rel_pulse. In the cycle after the pulse, grant is low and a clear write (op code 10) is requested, which leaves the lock word at 0.
- R9: At most one request is outstanding. A request that is not yet accepted keeps valid high and its op code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Client asks for the lock (level) |
| rel_pulse | input | 1 | One-cycle release from the client while granted |
| grant | output | 1 | Lock is held for the client |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | 00 read, 01 test-and-set (writes 1), 10 clear write (writes 0) |
| mem_rsp_valid | input | 1 | One-cycle response pulse |
| mem_rsp_data | input | 1 | Old lock value: 0 clear, 1 busy |

## Verification
The bench measures how long the port stays quiet after each failed test-and-set. A design that doubled the delay before its first use, or never stopped at the maximum, would give the wrong run of gaps. A second acquisition after a success checks that the delay returns to the minimum; a design that kept the old delay would start with a long first gap. The bench holds the lock busy for a long time to confirm that no atomic request leaks out while polling. It also checks that the test-and-set follows a clear read at once, which a design with a delay on the fast path would miss. Stalls on ready confirm that requests stay stable and that the backoff timing does not depend on accept latency.

// File: rtl/lkr_pkg.sv
package lkr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_TAS   = 2'b01,
        OP_CLEAR = 2'b10
    } lk_op_e;

    localparam logic LOCK_CLEAR = 1'b0;
    localparam logic LOCK_BUSY  = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_TAS_REQ,
        ST_TAS_WAIT,
        ST_BACKOFF,
        ST_HELD,
        ST_REL_REQ,
        ST_REL_WAIT
    } lk_state_e;

    typedef struct packed {
        logic   valid;
        lk_op_e op;
    } lk_req_t;

endpackage

// File: rtl/lkr_backoff.sv
module lkr_backoff #(
    parameter int MIN_DELAY = 4,
    parameter int MAX_DELAY = 32,
    localparam int DW = $clog2(MAX_DELAY + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          collide,
    output logic          expired,
    output logic [DW-1:0] delay_o
);
    localparam logic [DW-1:0] MIN_V = DW'(MIN_DELAY);
    localparam logic [DW-1:0] MAX_V = DW'(MAX_DELAY);

    logic [DW-1:0] cur_q;
    logic [DW-1:0] tmr_q;
    logic [DW:0]   dbl;
    logic [DW-1:0] cur_next;

    always_comb begin
        dbl      = {cur_q, 1'b0};
        cur_next = (dbl > {1'b0, MAX_V}) ? MAX_V : dbl[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cur_q <= MIN_V;
            tmr_q <= '0;
        end else if (collide) begin
            tmr_q <= cur_q;
            cur_q <= cur_next;
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign expired = (tmr_q == DW'(1));
    assign delay_o = cur_q;
endmodule

// File: rtl/lkr_fsm.sv
module lkr_fsm
    import lkr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    acq_req,
    input  logic    rel_pulse,
    input  logic    req_ready,
    input  logic    rsp_valid,
    input  logic    rsp_data,
    input  logic    bo_expired,
    output lk_req_t req,
    output logic    grant,
    output logic    bo_restart,
    output logic    bo_collide
);
    lk_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        bo_restart = 1'b0;
        bo_collide = 1'b0;
        unique case (st_q)
            ST_IDLE: if (acq_req) begin
                st_d       = ST_POLL_REQ;
                bo_restart = 1'b1;
            end
            ST_POLL_REQ:  if (req_ready) st_d = ST_POLL_WAIT;
            ST_POLL_WAIT: if (rsp_valid)
                st_d = (rsp_data == LOCK_CLEAR) ? ST_TAS_REQ : ST_POLL_REQ;
            ST_TAS_REQ:   if (req_ready) st_d = ST_TAS_WAIT;
            ST_TAS_WAIT: if (rsp_valid) begin
                if (rsp_data == LOCK_CLEAR) begin
                    st_d       = ST_HELD;
                    bo_restart = 1'b1;
                end else begin
                    st_d       = ST_BACKOFF;
                    bo_collide = 1'b1;
                end
            end
            ST_BACKOFF:  if (bo_expired) st_d = ST_POLL_REQ;
            ST_HELD:     if (rel_pulse)  st_d = ST_REL_REQ;
            ST_REL_REQ:  if (req_ready)  st_d = ST_REL_WAIT;
            ST_REL_WAIT: if (rsp_valid)  st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req.valid = 1'b0;
        req.op    = OP_READ;
        unique case (st_q)
            ST_POLL_REQ: req.valid = 1'b1;
            ST_TAS_REQ: begin
                req.valid = 1'b1;
                req.op    = OP_TAS;
            end
            ST_REL_REQ: begin
                req.valid = 1'b1;
                req.op    = OP_CLEAR;
            end
            default: ;
        endcase
    end

    assign grant = (st_q == ST_HELD);
endmodule

// File: rtl/lock_requester.sv
module lock_requester
    import lkr_pkg::*;
#(
    parameter int MIN_DELAY = 4,
    parameter int MAX_DELAY = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acq_req,
    input  logic       rel_pulse,
    output logic       grant,
    output logic       mem_req_valid,
    input  logic       mem_req_ready,
    output logic [1:0] mem_req_op,
    input  logic       mem_rsp_valid,
    input  logic       mem_rsp_data
);
    localparam int DW = $clog2(MAX_DELAY + 1);

    lk_req_t       req;
    logic          bo_restart;
    logic          bo_collide;
    logic          bo_expired;
    logic [DW-1:0] bo_delay;

    lkr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acq_req    (acq_req),
        .rel_pulse  (rel_pulse),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_data   (mem_rsp_data),
        .bo_expired (bo_expired),
        .req        (req),
        .grant      (grant),
        .bo_restart (bo_restart),
        .bo_collide (bo_collide)
    );

    lkr_backoff #(
        .MIN_DELAY (MIN_DELAY),
        .MAX_DELAY (MAX_DELAY)
    ) u_backoff (
        .clk     (clk),
        .rst     (rst),
        .restart (bo_restart),
        .collide (bo_collide),
        .expired (bo_expired),
        .delay_o (bo_delay)
    );

    assign mem_req_valid = req.valid;
    assign mem_req_op    = req.op;
endmodule

// File: rtl/lkr_chk.sv
module lkr_chk #(
    parameter int MIN_DELAY = 4,
    parameter int MAX_DELAY = 32,
    localparam int DW = $clog2(MAX_DELAY + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rel_pulse,
    input logic          grant,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [1:0]    mem_req_op,
    input logic          mem_rsp_valid,
    input logic          mem_rsp_data,
    input logic [DW-1:0] bo_delay
);
    logic       outstanding;
    logic [1:0] acc_op;
    logic       rd_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            acc_op      <= 2'b00;
            rd_clear    <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                outstanding <= 1'b1;
                acc_op      <= mem_req_op;
                if (mem_req_op == 2'b01) rd_clear <= 1'b0;
            end else if (mem_rsp_valid) begin
                outstanding <= 1'b0;
                if (acc_op == 2'b00) rd_clear <= !mem_rsp_data;
            end
        end
    end

    function automatic int sat_dbl(input int d);
        return (2 * d > MAX_DELAY) ? MAX_DELAY : 2 * d;
    endfunction

    // R9
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !outstanding);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op));
    // R2
    tas_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_op == 2'b01 |-> rd_clear);
    // R2
    busy_repoll_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && acc_op == 2'b00 && mem_rsp_data |=> mem_req_valid && mem_req_op == 2'b00);
    // R3
    tas_prompt_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && acc_op == 2'b00 && !mem_rsp_data |=> mem_req_valid && mem_req_op == 2'b01);
    // R4
    grant_on_win_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && acc_op == 2'b01 && !mem_rsp_data |=> grant);
    // R5
    quiet_backoff_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && acc_op == 2'b01 && mem_rsp_data |=> !mem_req_valid);
    // R7
    delay_double_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && acc_op == 2'b01 && mem_rsp_data |=>
        int'(bo_delay) == sat_dbl(int'($past(bo_delay))));
    // R7
    delay_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bo_delay) >= MIN_DELAY && int'(bo_delay) <= MAX_DELAY);
    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        grant && !rel_pulse |=> grant);
    // R8
    release_write_chk: assert property (@(posedge clk) disable iff (rst)
        grant && rel_pulse |=> !grant && mem_req_valid && mem_req_op == 2'b10);
endmodule

bind lock_requester lkr_chk #(
    .MIN_DELAY (MIN_DELAY),
    .MAX_DELAY (MAX_DELAY)
) u_lkr_chk (
    .clk           (clk),
    .rst           (rst),
    .rel_pulse     (rel_pulse),
    .grant         (grant),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_op    (mem_req_op),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .bo_delay      (bo_delay)
);

// File: tb/lock_requester_bench.sv
`timescale 1ns/1ps
module lock_requester_bench;
    localparam int MIN_D = 4;
    localparam int MAX_D = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq_req = 1'b0;
    logic       rel_pulse = 1'b0;
    logic       grant;
    logic       mem_req_valid;
    logic       mem_req_ready;
    logic [1:0] mem_req_op;
    logic       mem_rsp_valid;
    logic       mem_rsp_data;

    always #2.5 clk = ~clk;

    lock_requester #(.MIN_DELAY(MIN_D), .MAX_DELAY(MAX_D)) u_lock_requester (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_pulse(rel_pulse),
        .grant(grant), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Shared memory model: lock word plus a rival that can win test-and-set races.
    logic       lock_word = 1'b0;
    logic       rival_hold = 1'b0;
    logic       stall_mode = 1'b0;
    logic       ready_r = 1'b1;
    logic [1:0] rsp_op = 2'b00;
    int         fail_target = 0;
    int         tas_fail_cnt = 0;
    int         cyc = 0;

    assign mem_req_ready = ready_r;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        ready_r <= stall_mode ? ~ready_r : 1'b1;
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            rsp_op        <= mem_req_op;
            case (mem_req_op)
                2'b00: mem_rsp_data <= lock_word | rival_hold;
                2'b01: begin
                    if (tas_fail_cnt < fail_target) begin
                        mem_rsp_data <= 1'b1;
                        tas_fail_cnt <= tas_fail_cnt + 1;
                    end else begin
                        mem_rsp_data <= lock_word | rival_hold;
                        lock_word    <= 1'b1;
                    end
                end
                default: begin
                    mem_rsp_data <= 1'b0;
                    lock_word    <= 1'b0;
                end
            endcase
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    // Port monitor, sampled on the falling edge.
    int   n_rd = 0, n_tas = 0, n_wr = 0, ngap = 0;
    int   gaps [16];
    int   fail_cyc = 0;
    bit   await_gap = 1'b0, exp_tas = 1'b0, exp_grant = 1'b0, prev_stall = 1'b0;
    logic [1:0] prev_op = 2'b00;

    always @(negedge clk) begin
        if (!rst) begin
            if (exp_tas) chk(mem_req_valid && mem_req_op == 2'b01, "R3 tas after clear read",
                             int'(mem_req_op), 1);
            if (exp_grant) chk(grant, "R4 grant after winning tas", int'(grant), 1);
            if (prev_stall) chk(mem_req_valid && mem_req_op == prev_op, "R9 request held",
                                int'(mem_req_op), int'(prev_op));
            if (await_gap && mem_req_valid) begin
                chk(mem_req_op == 2'b00, "R5 read after backoff", int'(mem_req_op), 0);
                if (ngap < 16) gaps[ngap] = cyc - fail_cyc;
                ngap++;
                await_gap = 1'b0;
            end
            exp_tas   = mem_rsp_valid && rsp_op == 2'b00 && !mem_rsp_data;
            exp_grant = mem_rsp_valid && rsp_op == 2'b01 && !mem_rsp_data;
            if (mem_rsp_valid && rsp_op == 2'b01 && mem_rsp_data) begin
                await_gap = 1'b1;
                fail_cyc  = cyc;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_op == 2'b00) n_rd++;
                else if (mem_req_op == 2'b01) n_tas++;
                else n_wr++;
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_op    = mem_req_op;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        forever begin
            tick();
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                summary();
            end
        end
    end

    task automatic acquire();
        int t = 0;
        acq_req = 1'b1;
        while (!grant && t < 3000) begin
            tick();
            t++;
        end
        acq_req = 1'b0;
        chk(grant, "R4 acquisition completes", int'(grant), 1);
    endtask

    task automatic release_lock();
        int w0 = n_wr;
        rel_pulse = 1'b1;
        tick();
        rel_pulse = 1'b0;
        chk(!grant && mem_req_valid && mem_req_op == 2'b10, "R8 clear write after release",
            int'(mem_req_op), 2);
        repeat (6) tick();
        chk(lock_word == 1'b0, "R8 lock word cleared", int'(lock_word), 0);
        chk(n_wr - w0 == 1, "R8 one release write", n_wr - w0, 1);
    endtask

    task automatic t_reset();
        repeat (4) tick();
        rst = 1'b0;
        tick();
        chk(!mem_req_valid, "R1 no request after reset", int'(mem_req_valid), 0);
        chk(!grant, "R1 grant low after reset", int'(grant), 0);
        repeat (5) tick();
        chk(!mem_req_valid && !grant, "R1 idle without acquire", int'(mem_req_valid), 0);
    endtask

    task automatic t_uncontended();
        int r0 = n_rd, s0 = n_tas;
        acquire();
        chk(n_rd - r0 == 1, "R3 single poll read", n_rd - r0, 1);
        chk(n_tas - s0 == 1, "R3 single tas", n_tas - s0, 1);
        chk(lock_word == 1'b1, "R4 lock word set", int'(lock_word), 1);
        repeat (10) tick();
        chk(grant, "R8 grant held", int'(grant), 1);
        release_lock();
    endtask

    task automatic t_poll_busy();
        int r0 = n_rd, s0 = n_tas;
        rival_hold = 1'b1;
        acq_req = 1'b1;
        repeat (40) tick();
        chk(n_tas - s0 == 0, "R2 no tas while busy", n_tas - s0, 0);
        chk(n_rd - r0 >= 10, "R2 keeps polling", n_rd - r0, 10);
        chk(!grant, "R2 no grant while busy", int'(grant), 0);
        rival_hold = 1'b0;
        acquire();
        chk(n_tas - s0 == 1, "R3 one tas once clear", n_tas - s0, 1);
        release_lock();
    endtask

    task automatic t_backoff(input int fails, input bit stall);
        int g0 = ngap;
        int d = MIN_D;
        stall_mode  = stall;
        fail_target = tas_fail_cnt + fails;
        acquire();
        stall_mode = 1'b0;
        chk(ngap - g0 == fails, "R5 one backoff per collision", ngap - g0, fails);
        for (int k = 0; k < fails; k++) begin
            if (k == 0) chk(gaps[g0 + k] == d + 1, "R6 first delay is minimum", gaps[g0 + k], d + 1);
            else        chk(gaps[g0 + k] == d + 1, "R7 doubled delay", gaps[g0 + k], d + 1);
            d = (2 * d > MAX_D) ? MAX_D : 2 * d;
        end
        release_lock();
    endtask

    initial begin
        t_reset();
        t_uncontended();
        t_poll_busy();
        t_backoff(6, 1'b0);
        t_backoff(2, 1'b0);
        t_backoff(3, 1'b1);
        repeat (5) tick();
        summary();
    end
endmodule